// File: doc/BRIEF.md
# Trap Entry Unit

This block arbitrates between an exception reported by the execution pipeline and the set of pending interrupt lines. It chooses the privilege level that will handle the trap and computes every state change that trap entry implies. In a single clock edge it produces the redirect PC, the new privilege, the cause and exception-PC values, the faulting address and the updated status word, together with write strobes that tell the register file which bank to update.

Interrupts are chosen in two levels. Lines that are not delegated and that machine level will accept come first. Only when none of these qualifies are the delegated lines considered, subject to the supervisor enable rules. Within the winning level the lowest-numbered line wins. A breakpoint exception can instead enter the debug handler, with a per-privilege enable. While the core is already in debug mode, any exception only redirects the PC to one of two fixed debug addresses.

Privileges are encoded U=0, S=1, M=3. The status word holds seven bits: bit 0 supervisor interrupt enable (SIE), bit 1 machine interrupt enable (MIE), bit 2 supervisor previous enable (SPIE), bit 3 machine previous enable (MPIE), bit 4 supervisor previous privilege (SPP), and bits 6:5 machine previous privilege (MPP).

Top module: `trap_entry`

## Requirements
- R1: During and after reset, with no trap taken, `take_o`, `m_we_o`, `s_we_o`, `bad_we_o` and `dbg_we_o` are 0, `prv_o` is 3 (M) and `pc_o` equals parameter `RESET_PC`.
- R2: A pending line whose bit in `irq_deleg_i` is clear is eligible when the current privilege is below M, or when it is M and status bit 1 (MIE) is set. An eligible line at machine level is taken even if a lower-numbered delegated line is also pending.
- R3: Delegated pending lines are considered only when no machine-level line is eligible. They are eligible at privilege U, or at privilege S with status bit 0 (SIE) set, and never at privilege M.
- R4: Among the eligible lines of the winning level, the lowest-numbered one is taken. Its cause value has bit XLEN-1 set and the line index in the low bits.
- R5: An exception presented in the same cycle as an eligible interrupt is taken instead. Its cause value is the exception code with bit XLEN-1 clear. The address is written (`bad_we_o`) only when `exc_has_addr_i` is set.
- R6: A trap goes to supervisor when the current privilege is U or S and the selected bit is set: the bit of `irq_deleg_i` for interrupts, or of `exc_deleg_i` for exceptions. A trap raised at M always goes to machine.
- R7: Supervisor entry sets `s_we_o` and `pc_o` = `stvec_i`, `epc_o` = `cur_pc_i` and `prv_o` = S. In the status word, SPIE takes the old SIE, SPP takes bit 0 of the old privilege and SIE clears.
- R8: Machine entry sets `m_we_o` and `pc_o` = `mtvec_i` with bit 0 cleared, `epc_o` = `cur_pc_i` and `prv_o` = M. In the status word, MPIE takes the old MIE, MPP takes the old privilege and MIE clears.
- R9: When `VEC_EN` is 1 and bit 0 of `mtvec_i` is 1, a machine-level interrupt adds 4 times its line index to the base. Exceptions always use the base, and with bit 0 clear interrupts use the base too.
- R10: An exception with code `BKPT_CODE` enters debug when bit [current privilege] of `ebrk_en_i` is set. Entry sets `dbg_we_o`, `dbg_cause_o` = `DBG_CODE`, `dbg_prv_o` = old privilege, `epc_o` = `cur_pc_i`, `prv_o` = M and `pc_o` = `DBG_ENTRY`. No cause or status bank is written.
- R11: While `dbg_act_i` is 1, a breakpoint exception redirects to `DBG_ENTRY` and any other exception to `DBG_EXC`. This changes no privilege and writes nothing else, and pending interrupts are not taken.
- R12: `take_o` and the write strobes rise on the clock edge that samples an accepted request and last one cycle. A cycle with no exception and no eligible interrupt yields no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_pend_i | input | NIRQ | Pending interrupt lines |
| irq_deleg_i | input | NIRQ | Interrupt delegation mask |
| exc_valid_i | input | 1 | Exception request this cycle |
| exc_code_i | input | $clog2(XLEN) | Exception code |
| exc_has_addr_i | input | 1 | Exception carries a faulting address |
| exc_addr_i | input | XLEN | Faulting address |
| exc_deleg_i | input | NEXC | Exception delegation mask |
| cur_pc_i | input | XLEN | PC of the trapping instruction |
| cur_prv_i | input | 2 | Current privilege |
| status_i | input | 7 | Current status word |
| mtvec_i | input | XLEN | Machine trap vector, bit 0 selects vectored mode |
| stvec_i | input | XLEN | Supervisor trap vector |
| dbg_act_i | input | 1 | Core is in debug mode |
| ebrk_en_i | input | 4 | Breakpoint-to-debug enable, indexed by privilege |
| take_o | output | 1 | Trap accepted strobe |
| pc_o | output | XLEN | Redirect PC |
| prv_o | output | 2 | New privilege |
| status_o | output | 7 | Updated status word |
| m_we_o | output | 1 | Write machine cause and exception-PC |
| s_we_o | output | 1 | Write supervisor cause and exception-PC |
| cause_o | output | XLEN | Cause value |
| epc_o | output | XLEN | Saved PC (exception-PC or debug PC) |
| bad_we_o | output | 1 | Write faulting-address register of the chosen bank |
| bad_o | output | XLEN | Faulting address |
| dbg_we_o | output | 1 | Write debug status and debug PC |
| dbg_cause_o | output | 3 | Debug entry cause |
| dbg_prv_o | output | 2 | Privilege saved on debug entry |

## Verification
The bench builds the unit with XLEN=32, 16 interrupt lines, 16 exception codes and `VEC_EN`=1. It uses `RESET_PC`=0x100, `DBG_ENTRY`=0x800, `DBG_EXC`=0x808 and breakpoint code 3. Turning on vectoring lets it tell machine interrupts apart by their redirect offset from 0x1000, and distinct debug addresses separate the two debug-mode exits. Sixteen lines are enough to pit a high machine line against a low delegated line, and exception code 8 is delegated while code 3 is not, so both delegation outcomes and the breakpoint fall-through path are reached.

// File: rtl/trap_pkg.sv
package trap_pkg;

   typedef enum logic [1:0] {
      PRV_U   = 2'd0,
      PRV_S   = 2'd1,
      PRV_RSV = 2'd2,
      PRV_M   = 2'd3
   } prv_e;

   typedef enum logic [2:0] {
      DST_NONE,
      DST_SUP,
      DST_MACH,
      DST_DBG_IN,
      DST_DBG_RE
   } dest_e;

   localparam int ST_W    = 7;
   localparam int ST_SIE  = 0;
   localparam int ST_MIE  = 1;
   localparam int ST_SPIE = 2;
   localparam int ST_MPIE = 3;
   localparam int ST_SPP  = 4;
   localparam int ST_MPP0 = 5;
   localparam int ST_MPP1 = 6;

endpackage

// File: rtl/trap_lsb_find.sv
module trap_lsb_find #(
   parameter int W  = 16,
   parameter int IW = 4
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   initial assert (W <= (1 << IW));

   always_comb begin
      found = |vec;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/trap_irq_pick.sv
module trap_irq_pick
   import trap_pkg::*;
#(
   parameter int NIRQ = 16,
   parameter int IW   = 5
) (
   input  logic [NIRQ-1:0] pend,
   input  logic [NIRQ-1:0] deleg,
   input  logic [1:0]      prv,
   input  logic            mie,
   input  logic            sie,
   input  logic            block,
   output logic            found,
   output logic [IW-1:0]   idx
);
   logic            m_en, s_en;
   logic [NIRQ-1:0] m_set, s_set, win_set;

   always_comb begin
      m_en    = (prv != PRV_M) || mie;
      s_en    = (prv == PRV_U) || ((prv == PRV_S) && sie);
      m_set   = pend & ~deleg & {NIRQ{m_en && !block}};
      s_set   = pend &  deleg & {NIRQ{s_en && !block}};
      win_set = (|m_set) ? m_set : s_set;
   end

   trap_lsb_find #(.W(NIRQ), .IW(IW)) u_find (
      .vec   (win_set),
      .found (found),
      .idx   (idx)
   );
endmodule

// File: rtl/trap_route.sv
module trap_route
   import trap_pkg::*;
#(
   parameter int          XLEN      = 32,
   parameter int          NIRQ      = 16,
   parameter int          NEXC      = 16,
   parameter int          IW        = 5,
   parameter bit          VEC_EN    = 1'b1,
   parameter int          BKPT_CODE = 3,
   parameter logic [63:0] DBG_ENTRY = 64'h800,
   parameter logic [63:0] DBG_EXC   = 64'h808
) (
   input  logic            exc_v,
   input  logic [IW-1:0]   exc_code,
   input  logic            exc_has_addr,
   input  logic [NEXC-1:0] exc_deleg,
   input  logic            irq_found,
   input  logic [IW-1:0]   irq_idx,
   input  logic [NIRQ-1:0] irq_deleg,
   input  logic [1:0]      prv,
   input  logic [ST_W-1:0] st,
   input  logic [XLEN-1:0] mtvec,
   input  logic [XLEN-1:0] stvec,
   input  logic            dbg_act,
   input  logic [3:0]      ebrk_en,
   output dest_e           dest,
   output logic [XLEN-1:0] nxt_pc,
   output logic [1:0]      nxt_prv,
   output logic [XLEN-1:0] nxt_cause,
   output logic [ST_W-1:0] nxt_st,
   output logic            nxt_bad_we
);
   localparam int CODES = 1 << IW;

   logic [CODES-1:0] ed_ext, id_ext;
   logic [IW-1:0]    sel_idx;
   logic             is_bkpt, sel_deleg, low_prv;
   logic [XLEN-1:0]  mbase, voff;

   assign ed_ext  = CODES'(exc_deleg);
   assign id_ext  = CODES'(irq_deleg);
   assign sel_idx = exc_v ? exc_code : irq_idx;
   assign is_bkpt = (exc_code == IW'(BKPT_CODE));
   assign low_prv = (prv == PRV_U) || (prv == PRV_S);
   assign sel_deleg = low_prv && (exc_v ? ed_ext[sel_idx] : id_ext[sel_idx]);
   assign mbase   = {mtvec[XLEN-1:1], 1'b0};

   generate
      if (VEC_EN) begin : g_vec
         assign voff = (mtvec[0] && !exc_v) ? (XLEN'(sel_idx) << 2) : '0;
      end else begin : g_flat
         assign voff = '0;
      end
   endgenerate

   always_comb begin
      dest       = DST_NONE;
      nxt_pc     = '0;
      nxt_prv    = prv;
      nxt_cause  = {~exc_v, {(XLEN-1-IW){1'b0}}, sel_idx};
      nxt_st     = st;
      nxt_bad_we = 1'b0;
      if (dbg_act) begin
         if (exc_v) begin
            dest   = DST_DBG_RE;
            nxt_pc = is_bkpt ? XLEN'(DBG_ENTRY) : XLEN'(DBG_EXC);
         end
      end else if (exc_v && is_bkpt && ebrk_en[prv]) begin
         dest    = DST_DBG_IN;
         nxt_pc  = XLEN'(DBG_ENTRY);
         nxt_prv = PRV_M;
      end else if (exc_v || irq_found) begin
         nxt_bad_we = exc_v && exc_has_addr;
         if (sel_deleg) begin
            dest            = DST_SUP;
            nxt_pc          = stvec;
            nxt_prv         = PRV_S;
            nxt_st[ST_SPIE] = st[ST_SIE];
            nxt_st[ST_SPP]  = prv[0];
            nxt_st[ST_SIE]  = 1'b0;
         end else begin
            dest            = DST_MACH;
            nxt_pc          = mbase + voff;
            nxt_prv         = PRV_M;
            nxt_st[ST_MPIE] = st[ST_MIE];
            nxt_st[ST_MPP1:ST_MPP0] = prv;
            nxt_st[ST_MIE]  = 1'b0;
         end
      end
   end
endmodule

// File: rtl/trap_entry.sv
module trap_entry
   import trap_pkg::*;
#(
   parameter int          XLEN      = 32,
   parameter int          NIRQ      = 16,
   parameter int          NEXC      = 16,
   parameter bit          VEC_EN    = 1'b1,
   parameter int          BKPT_CODE = 3,
   parameter logic [2:0]  DBG_CODE  = 3'd1,
   parameter logic [63:0] RESET_PC  = 64'h100,
   parameter logic [63:0] DBG_ENTRY = 64'h800,
   parameter logic [63:0] DBG_EXC   = 64'h808,
   localparam int         IW        = $clog2(XLEN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NIRQ-1:0] irq_pend_i,
   input  logic [NIRQ-1:0] irq_deleg_i,
   input  logic            exc_valid_i,
   input  logic [IW-1:0]   exc_code_i,
   input  logic            exc_has_addr_i,
   input  logic [XLEN-1:0] exc_addr_i,
   input  logic [NEXC-1:0] exc_deleg_i,
   input  logic [XLEN-1:0] cur_pc_i,
   input  logic [1:0]      cur_prv_i,
   input  logic [6:0]      status_i,
   input  logic [XLEN-1:0] mtvec_i,
   input  logic [XLEN-1:0] stvec_i,
   input  logic            dbg_act_i,
   input  logic [3:0]      ebrk_en_i,
   output logic            take_o,
   output logic [XLEN-1:0] pc_o,
   output logic [1:0]      prv_o,
   output logic [6:0]      status_o,
   output logic            m_we_o,
   output logic            s_we_o,
   output logic [XLEN-1:0] cause_o,
   output logic [XLEN-1:0] epc_o,
   output logic            bad_we_o,
   output logic [XLEN-1:0] bad_o,
   output logic            dbg_we_o,
   output logic [2:0]      dbg_cause_o,
   output logic [1:0]      dbg_prv_o
);
   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         initial $fatal(1, "trap_entry: XLEN must be 32 or 64");
      end
      if (NIRQ < 1 || NIRQ > XLEN - 1) begin : g_bad_nirq
         initial $fatal(1, "trap_entry: NIRQ out of range");
      end
      if (NEXC < 1 || NEXC > XLEN) begin : g_bad_nexc
         initial $fatal(1, "trap_entry: NEXC out of range");
      end
      if (BKPT_CODE < 0 || BKPT_CODE >= XLEN) begin : g_bad_bkpt
         initial $fatal(1, "trap_entry: BKPT_CODE out of range");
      end
   endgenerate

   logic            irq_found;
   logic [IW-1:0]   irq_idx;
   dest_e           dest;
   logic [XLEN-1:0] nxt_pc, nxt_cause;
   logic [1:0]      nxt_prv;
   logic [ST_W-1:0] nxt_st;
   logic            nxt_bad_we;

   trap_irq_pick #(.NIRQ(NIRQ), .IW(IW)) u_pick (
      .pend  (irq_pend_i),
      .deleg (irq_deleg_i),
      .prv   (cur_prv_i),
      .mie   (status_i[ST_MIE]),
      .sie   (status_i[ST_SIE]),
      .block (dbg_act_i),
      .found (irq_found),
      .idx   (irq_idx)
   );

   trap_route #(
      .XLEN(XLEN), .NIRQ(NIRQ), .NEXC(NEXC), .IW(IW), .VEC_EN(VEC_EN),
      .BKPT_CODE(BKPT_CODE), .DBG_ENTRY(DBG_ENTRY), .DBG_EXC(DBG_EXC)
   ) u_route (
      .exc_v        (exc_valid_i),
      .exc_code     (exc_code_i),
      .exc_has_addr (exc_has_addr_i),
      .exc_deleg    (exc_deleg_i),
      .irq_found    (irq_found),
      .irq_idx      (irq_idx),
      .irq_deleg    (irq_deleg_i),
      .prv          (cur_prv_i),
      .st           (status_i),
      .mtvec        (mtvec_i),
      .stvec        (stvec_i),
      .dbg_act      (dbg_act_i),
      .ebrk_en      (ebrk_en_i),
      .dest         (dest),
      .nxt_pc       (nxt_pc),
      .nxt_prv      (nxt_prv),
      .nxt_cause    (nxt_cause),
      .nxt_st       (nxt_st),
      .nxt_bad_we   (nxt_bad_we)
   );

   logic bank_wr;
   assign bank_wr = (dest == DST_SUP) || (dest == DST_MACH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o      <= 1'b0;
         m_we_o      <= 1'b0;
         s_we_o      <= 1'b0;
         bad_we_o    <= 1'b0;
         dbg_we_o    <= 1'b0;
         pc_o        <= XLEN'(RESET_PC);
         prv_o       <= PRV_M;
         status_o    <= '0;
         cause_o     <= '0;
         epc_o       <= '0;
         bad_o       <= '0;
         dbg_cause_o <= '0;
         dbg_prv_o   <= '0;
      end else begin
         take_o   <= (dest != DST_NONE);
         m_we_o   <= (dest == DST_MACH);
         s_we_o   <= (dest == DST_SUP);
         bad_we_o <= nxt_bad_we;
         dbg_we_o <= (dest == DST_DBG_IN);
         if (dest != DST_NONE) begin
            pc_o  <= nxt_pc;
            prv_o <= nxt_prv;
         end
         if (bank_wr) begin
            status_o <= nxt_st;
            cause_o  <= nxt_cause;
         end
         if (bank_wr || dest == DST_DBG_IN) epc_o <= cur_pc_i;
         if (nxt_bad_we) bad_o <= exc_addr_i;
         if (dest == DST_DBG_IN) begin
            dbg_cause_o <= DBG_CODE;
            dbg_prv_o   <= cur_prv_i;
         end
      end
   end

   // R12: an exception is always accepted on the next edge
   a_r12_exc_taken: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid_i |=> take_o);
   // R12: nothing pending and no exception means no strobe
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_valid_i && irq_pend_i == '0) |=> !take_o);
   // R11: in debug mode only exceptions redirect
   a_r11_dbg_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_act_i && !exc_valid_i) |=> !take_o);
   // R11: debug-mode redirect writes no bank
   a_r11_dbg_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_act_i && exc_valid_i) |=> (take_o && !m_we_o && !s_we_o && !dbg_we_o && !bad_we_o));
   // R10: at most one destination per accepted trap
   a_r10_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({m_we_o, s_we_o, dbg_we_o}));
   // R12: write strobes only with the take strobe
   a_r12_we_with_take: assert property (@(posedge clk) disable iff (!rst_n)
      (m_we_o || s_we_o || dbg_we_o) |-> take_o);
   // R7: supervisor entry lands in S with SIE clear
   a_r7_sup_entry: assert property (@(posedge clk) disable iff (!rst_n)
      s_we_o |-> (prv_o == PRV_S && !status_o[ST_SIE]));
   // R8: machine entry lands in M with MIE clear and an aligned PC
   a_r8_mach_entry: assert property (@(posedge clk) disable iff (!rst_n)
      m_we_o |-> (prv_o == PRV_M && !status_o[ST_MIE] && !pc_o[0]));
   // R5: an address is only recorded for exceptions
   a_r5_addr_exc_only: assert property (@(posedge clk) disable iff (!rst_n)
      bad_we_o |-> ((m_we_o || s_we_o) && !cause_o[XLEN-1]));
endmodule

// File: tb/trap_entry_test.sv
module trap_entry_test;
   localparam int XLEN = 32;
   localparam int NIRQ = 16;
   localparam int NEXC = 16;
   localparam int IW   = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NIRQ-1:0] irq_pend, irq_deleg;
   logic            exc_valid, exc_has_addr, dbg_act;
   logic [IW-1:0]   exc_code;
   logic [XLEN-1:0] exc_addr, cur_pc, mtvec, stvec;
   logic [NEXC-1:0] exc_deleg;
   logic [1:0]      cur_prv;
   logic [6:0]      status;
   logic [3:0]      ebrk_en;
   logic            take, m_we, s_we, bad_we, dbg_we;
   logic [XLEN-1:0] pc, cause, epc, bad;
   logic [1:0]      prv, dbg_prv;
   logic [6:0]      status_n;
   logic [2:0]      dbg_cause;

   int total = 0;
   int bad_cnt = 0;

   always #4 clk = ~clk;

   trap_entry #(
      .XLEN(XLEN), .NIRQ(NIRQ), .NEXC(NEXC), .VEC_EN(1'b1), .BKPT_CODE(3),
      .DBG_CODE(3'd1), .RESET_PC(64'h100), .DBG_ENTRY(64'h800), .DBG_EXC(64'h808)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .irq_pend_i(irq_pend), .irq_deleg_i(irq_deleg),
      .exc_valid_i(exc_valid), .exc_code_i(exc_code),
      .exc_has_addr_i(exc_has_addr), .exc_addr_i(exc_addr),
      .exc_deleg_i(exc_deleg), .cur_pc_i(cur_pc), .cur_prv_i(cur_prv),
      .status_i(status), .mtvec_i(mtvec), .stvec_i(stvec),
      .dbg_act_i(dbg_act), .ebrk_en_i(ebrk_en),
      .take_o(take), .pc_o(pc), .prv_o(prv), .status_o(status_n),
      .m_we_o(m_we), .s_we_o(s_we), .cause_o(cause), .epc_o(epc),
      .bad_we_o(bad_we), .bad_o(bad), .dbg_we_o(dbg_we),
      .dbg_cause_o(dbg_cause), .dbg_prv_o(dbg_prv)
   );

   typedef struct packed {
      logic [3:0]  rq;
      logic [1:0]  prv;
      logic [6:0]  st;
      logic [15:0] pend;
      logic [15:0] idel;
      logic        ev;
      logic [4:0]  ec;
      logic        ea;
      logic [3:0]  ebk;
      logic        dbg;
      logic        x_take;
      logic [31:0] x_pc;
      logic [1:0]  x_prv;
      logic [31:0] x_cause;
      logic [3:0]  x_we;      // {m, s, dbg, bad}
      logic [6:0]  x_st;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t TBL [NV] = '{
      // R4: lowest of two machine lines, vectored
      '{4'd4,  2'd3, 7'h02, 16'h0880, 16'h0000, 1'b0, 5'd0, 1'b0, 4'h0, 1'b0,
        1'b1, 32'h101C, 2'd3, 32'h80000007, 4'b1000, 7'h68},
      // R2: M with MIE clear takes nothing
      '{4'd2,  2'd3, 7'h00, 16'h0080, 16'h0000, 1'b0, 5'd0, 1'b0, 4'h0, 1'b0,
        1'b0, 32'h0, 2'd0, 32'h0, 4'b0000, 7'h00},
      // R2: U takes machine line 5 over delegated line 1
      '{4'd2,  2'd0, 7'h00, 16'h0022, 16'h0002, 1'b0, 5'd0, 1'b0, 4'h0, 1'b0,
        1'b1, 32'h1014, 2'd3, 32'h80000005, 4'b1000, 7'h00},
      // R3: delegated line taken from U
      '{4'd3,  2'd0, 7'h00, 16'h0002, 16'h0002, 1'b0, 5'd0, 1'b0, 4'h0, 1'b0,
        1'b1, 32'h2000, 2'd1, 32'h80000001, 4'b0100, 7'h00},
      // R3: S with SIE clear blocks delegated line
      '{4'd3,  2'd1, 7'h00, 16'h0002, 16'h0002, 1'b0, 5'd0, 1'b0, 4'h0, 1'b0,
        1'b0, 32'h0, 2'd0, 32'h0, 4'b0000, 7'h00},
      // R7: S with SIE set, status update
      '{4'd7,  2'd1, 7'h01, 16'h0002, 16'h0002, 1'b0, 5'd0, 1'b0, 4'h0, 1'b0,
        1'b1, 32'h2000, 2'd1, 32'h80000001, 4'b0100, 7'h14},
      // R3: delegated line never taken in M
      '{4'd3,  2'd3, 7'h02, 16'h0002, 16'h0002, 1'b0, 5'd0, 1'b0, 4'h0, 1'b0,
        1'b0, 32'h0, 2'd0, 32'h0, 4'b0000, 7'h00},
      // R5: exception beats pending interrupt, not vectored
      '{4'd5,  2'd3, 7'h02, 16'h0080, 16'h0000, 1'b1, 5'd2, 1'b1, 4'h0, 1'b0,
        1'b1, 32'h1000, 2'd3, 32'h00000002, 4'b1001, 7'h68},
      // R6: delegated exception from U
      '{4'd6,  2'd0, 7'h00, 16'h0000, 16'h0000, 1'b1, 5'd8, 1'b0, 4'h0, 1'b0,
        1'b1, 32'h2000, 2'd1, 32'h00000008, 4'b0100, 7'h00},
      // R6: same code from M stays in M
      '{4'd6,  2'd3, 7'h00, 16'h0000, 16'h0000, 1'b1, 5'd8, 1'b0, 4'h0, 1'b0,
        1'b1, 32'h1000, 2'd3, 32'h00000008, 4'b1000, 7'h60},
      // R10: breakpoint in S with S enable enters debug
      '{4'd10, 2'd1, 7'h00, 16'h0000, 16'h0000, 1'b1, 5'd3, 1'b0, 4'h2, 1'b0,
        1'b1, 32'h0800, 2'd3, 32'h0, 4'b0010, 7'h00},
      // R10: breakpoint in U without U enable is a plain trap
      '{4'd10, 2'd0, 7'h00, 16'h0000, 16'h0000, 1'b1, 5'd3, 1'b1, 4'h2, 1'b0,
        1'b1, 32'h1000, 2'd3, 32'h00000003, 4'b1001, 7'h00},
      // R11: breakpoint in debug mode
      '{4'd11, 2'd0, 7'h00, 16'h0000, 16'h0000, 1'b1, 5'd3, 1'b0, 4'h0, 1'b1,
        1'b1, 32'h0800, 2'd0, 32'h0, 4'b0000, 7'h00},
      // R11: other exception in debug mode
      '{4'd11, 2'd0, 7'h00, 16'h0000, 16'h0000, 1'b1, 5'd2, 1'b0, 4'h0, 1'b1,
        1'b1, 32'h0808, 2'd0, 32'h0, 4'b0000, 7'h00},
      // R11: interrupt ignored in debug mode
      '{4'd11, 2'd3, 7'h02, 16'h0080, 16'h0000, 1'b0, 5'd0, 1'b0, 4'h0, 1'b1,
        1'b0, 32'h0, 2'd0, 32'h0, 4'b0000, 7'h00},
      // R2: machine line 9 beats delegated line 1 while in S
      '{4'd2,  2'd1, 7'h01, 16'h0202, 16'h0002, 1'b0, 5'd0, 1'b0, 4'h0, 1'b0,
        1'b1, 32'h1024, 2'd3, 32'h80000009, 4'b1000, 7'h21}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad_cnt++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      irq_pend = '0; irq_deleg = '0; exc_valid = 1'b0; exc_code = '0;
      exc_has_addr = 1'b0; dbg_act = 1'b0; ebrk_en = '0;
      cur_prv = 2'd3; status = '0;
   endtask

   initial begin
      #(8 * 100000);
      bad_cnt++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad_cnt);
      $finish;
   end

   initial begin
      vec_t v;
      string rs;
      idle();
      exc_addr = 32'hBAD0; cur_pc = 32'h4000; mtvec = 32'h1001;
      stvec = 32'h2000; exc_deleg = 16'h0100;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(take == 1'b0, "R1", "take", 32'(take), 32'd0);
      chk(prv == 2'd3, "R1", "prv", 32'(prv), 32'd3);
      chk(pc == 32'h100, "R1", "pc", pc, 32'h100);
      chk({m_we, s_we, dbg_we, bad_we} == 4'b0, "R1", "strobes",
          32'({m_we, s_we, dbg_we, bad_we}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(take == 1'b0, "R1", "take after release", 32'(take), 32'd0);

      for (int i = 0; i < NV; i++) begin
         v = TBL[i];
         rs = $sformatf("R%0d", v.rq);
         cur_prv = v.prv; status = v.st; irq_pend = v.pend; irq_deleg = v.idel;
         exc_valid = v.ev; exc_code = v.ec; exc_has_addr = v.ea;
         ebrk_en = v.ebk; dbg_act = v.dbg;
         @(negedge clk);
         chk(take == v.x_take, rs, $sformatf("take v%0d", i), 32'(take), 32'(v.x_take));
         if (v.x_take) begin
            chk(pc == v.x_pc, rs, $sformatf("pc v%0d", i), pc, v.x_pc);
            chk(prv == v.x_prv, rs, $sformatf("prv v%0d", i), 32'(prv), 32'(v.x_prv));
            chk({m_we, s_we, dbg_we, bad_we} == v.x_we, rs, $sformatf("we v%0d", i),
                32'({m_we, s_we, dbg_we, bad_we}), 32'(v.x_we));
            if (v.x_we[3] || v.x_we[2]) begin
               chk(cause == v.x_cause, rs, $sformatf("cause v%0d", i), cause, v.x_cause);
               chk(status_n == v.x_st, rs, $sformatf("status v%0d", i),
                   32'(status_n), 32'(v.x_st));
            end
         end
         idle();
         @(negedge clk);
         // R12: strobe lasts a single cycle
         chk(take == 1'b0, "R12", $sformatf("strobe drop v%0d", i), 32'(take), 32'd0);
      end

      // R10: debug entry fields
      cur_prv = 2'd1; exc_valid = 1'b1; exc_code = 5'd3; ebrk_en = 4'h2;
      cur_pc = 32'h4444;
      @(negedge clk);
      chk(dbg_we && dbg_prv == 2'd1, "R10", "saved prv", 32'(dbg_prv), 32'd1);
      chk(dbg_cause == 3'd1, "R10", "debug cause", 32'(dbg_cause), 32'd1);
      chk(epc == 32'h4444, "R10", "dpc", epc, 32'h4444);
      idle();
      @(negedge clk);

      // R7: supervisor exception with address
      cur_prv = 2'd1; status = 7'h01; exc_valid = 1'b1; exc_code = 5'd8;
      exc_has_addr = 1'b1; exc_addr = 32'hCAFE0; cur_pc = 32'h5550;
      @(negedge clk);
      chk(s_we && bad_we, "R7", "bank strobes", 32'({s_we, bad_we}), 32'd3);
      chk(bad == 32'hCAFE0, "R7", "bad addr", bad, 32'hCAFE0);
      chk(epc == 32'h5550, "R7", "epc", epc, 32'h5550);
      chk(status_n == 7'h14, "R7", "status", 32'(status_n), 32'h14);
      idle();
      @(negedge clk);

      // R9: direct mode ignores line index
      mtvec = 32'h3000; cur_prv = 2'd3; status = 7'h02; irq_pend = 16'h0080;
      @(negedge clk);
      chk(pc == 32'h3000, "R9", "direct pc", pc, 32'h3000);
      chk(cause == 32'h80000007, "R4", "direct cause", cause, 32'h80000007);
      idle();
      @(negedge clk);

      // R12: a held request is taken every cycle
      mtvec = 32'h1001; cur_prv = 2'd3; exc_valid = 1'b1; exc_code = 5'd2;
      @(negedge clk);
      chk(take == 1'b1, "R12", "held 1", 32'(take), 32'd1);
      @(negedge clk);
      chk(take == 1'b1, "R12", "held 2", 32'(take), 32'd1);
      idle();
      @(negedge clk);

      // R1: reset again mid-run
      rst_n = 1'b0;
      @(negedge clk);
      chk(pc == 32'h100 && prv == 2'd3 && !take, "R1", "re-reset pc", pc, 32'h100);
      rst_n = 1'b1;
      @(negedge clk);

      $display("  test done: total=%0d bad=%0d", total, bad_cnt);
      $finish;
   end
endmodule